// File: doc/BRIEF.md
# Lowest-Index Priority Interrupt Controller

This block collects interrupt requests from up to `NSRC` peripheral sources (timers, DMA channels, serial units) into a source-pending register. Each request is a single-cycle pulse on `req_valid` with the source number on `req_idx`. Whenever source-pending changes, the block re-evaluates it. The lowest-numbered pending source wins. The block posts the winner two ways: as a one-hot bit ORed into an interrupt-pending register, and as a binary index in an offset register. A single level-sensitive `irq` line to the processor stays high for as long as any source is pending.

Software uses a small register bus to read the three registers and to acknowledge sources. Writing ones to source-pending removes those sources and triggers an immediate re-evaluation. That re-evaluation either posts the next winner or, if nothing is left, drops `irq`. A request that arrives in the same cycle as an acknowledge is never lost.

Top module: `prio_irq_ctrl`

## Requirements
- R1: Reset (active-low `rst_n`, asynchronous) clears source-pending, interrupt-pending and offset to 0, and `irq` reads 0.
- R2: A cycle with `req_valid`=1 and `req_idx`=n (n < NSRC) leaves bit n of source-pending set after the next rising edge.
- R3: After any cycle with an in-range request or a source-pending write, if source-pending is nonzero, offset holds the index of its lowest set bit.
- R4: The winner posted in R3 is ORed into interrupt-pending. Bits already set there are kept.
- R5: `irq` is 1 exactly while source-pending is nonzero.
- R6: A write to address 0 clears the source-pending bits that are 1 in `wdata`. Bits written as 0 keep their value.
- R7: A source-pending write posts the next lowest pending source at once. If that write empties the register, `irq` falls and interrupt-pending and offset are left unchanged.
- R8: A request for source n in the same cycle as a write that clears bit n leaves bit n set.
- R9: A write to address 1 clears the interrupt-pending bits that are 1 in `wdata`. A winner posted in the same cycle is still set afterwards.
- R10: A write to address 2 loads `wdata[IDX_W-1:0]` into offset. A winner posted in the same cycle takes precedence over the written value.
- R11: `rdata` shows, zero-extended, source-pending at address 0, interrupt-pending at 1 and offset at 2. Address 3 reads 0, and writes to it change nothing.
- R12: A request whose index is NSRC or larger is ignored and does not trigger an evaluation.
- R13: In a cycle with neither a request nor a write, all three registers hold their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | One-cycle interrupt request strobe |
| req_idx | input | IDX_W | Source number of the request |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register select: 0 source-pending, 1 interrupt-pending, 2 offset |
| wdata | input | DATA_W | Write data (clear mask or offset value) |
| rdata | output | DATA_W | Read data for the register selected by `addr` |
| irq | output | 1 | Level interrupt to the processor |

## Verification
The bench builds the block with NSRC = 20 and DATA_W = 32. The request index is then five bits wide but only twenty sources exist, so indices 20 to 31 can be driven and their rejection (R12) observed. The 32-bit read port also carries twelve unused high bits that must read as zero. The topmost source, bit 19, is exercised alongside bit 0, so both ends of the priority scan are covered. The bench also checks all same-cycle collisions between a request and each of the three writes.

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl #(
  parameter int NSRC   = 32,
  parameter int DATA_W = 32,
  localparam int IDX_W = $clog2(NSRC)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [IDX_W-1:0]  req_idx,
  input  logic              wr_en,
  input  logic [1:0]        addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              irq
);

  logic [NSRC-1:0]  src_pend, int_pend, req_vec, src_nxt, win_hot;
  logic [IDX_W-1:0] offset, win_idx;
  logic             sp_wr, ip_wr, of_wr, eval, post;

  assign sp_wr = wr_en && (addr == 2'd0);
  assign ip_wr = wr_en && (addr == 2'd1);
  assign of_wr = wr_en && (addr == 2'd2);

  always_comb begin
    for (int i = 0; i < NSRC; i++)
      req_vec[i] = req_valid && (req_idx == IDX_W'(i));
  end

  assign src_nxt = (src_pend & ~(sp_wr ? wdata[NSRC-1:0] : '0)) | req_vec;
  assign eval    = (|req_vec) || sp_wr;
  assign post    = eval && (|src_nxt);

  always_comb begin
    win_idx = '0;
    for (int i = NSRC - 1; i >= 0; i--)
      if (src_nxt[i]) win_idx = IDX_W'(i);
  end

  assign win_hot = NSRC'(1) << win_idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_pend <= '0;
      int_pend <= '0;
      offset   <= '0;
    end else begin
      src_pend <= src_nxt;
      int_pend <= (int_pend & ~(ip_wr ? wdata[NSRC-1:0] : '0)) | (post ? win_hot : '0);
      if (post)       offset <= win_idx;
      else if (of_wr) offset <= wdata[IDX_W-1:0];
    end
  end

  assign irq = |src_pend;

  always_comb begin
    case (addr)
      2'd0:    rdata = DATA_W'(src_pend);
      2'd1:    rdata = DATA_W'(int_pend);
      2'd2:    rdata = DATA_W'(offset);
      default: rdata = '0;
    endcase
  end

  logic [NSRC-1:0] below_ofs;
  assign below_ofs = src_pend & ((NSRC'(1) << offset) - NSRC'(1));

  AST_REQ_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && int'(req_idx) < NSRC) |=> src_pend[$past(req_idx)]); // R2
  AST_OFS_LOWEST: assert property (@(posedge clk) disable iff (!rst_n)
    ((req_valid && int'(req_idx) < NSRC) || sp_wr) |=>
      (src_pend == '0) || (src_pend[offset] && below_ofs == '0)); // R3
  AST_WIN_POSTED: assert property (@(posedge clk) disable iff (!rst_n)
    ((req_valid && int'(req_idx) < NSRC) || sp_wr) |=>
      (src_pend == '0) || int_pend[offset]); // R4
  AST_CLR_NO_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (sp_wr && !req_valid) |=> ((src_pend & ~$past(src_pend)) == '0)); // R6
  AST_CLR_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    sp_wr |=> (($past(src_pend) & ~$past(wdata[NSRC-1:0]) & ~src_pend) == '0)); // R6
  AST_IRQ_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq) |-> $past(sp_wr)); // R7
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_valid && !wr_en) |=> ($stable(src_pend) && $stable(int_pend) && $stable(offset))); // R13

endmodule

// File: tb/prio_irq_ctrl_tb.sv
module prio_irq_ctrl_tb_top;
  localparam int NSRC = 20;
  localparam int DW   = 32;
  localparam int IW   = $clog2(NSRC);
  localparam int NV   = 14;
  localparam int VW   = 1 + 5 + 1 + 2 + 32 + 20 + 20 + 5 + 1;

  logic clk = 0, rst_n = 0, req_valid = 0, wr_en = 0, irq;
  logic [IW-1:0] req_idx = '0;
  logic [1:0]    addr = '0;
  logic [DW-1:0] wdata = '0, rdata;
  int checks = 0, fails = 0;

  always #10 clk = ~clk;

  prio_irq_ctrl #(.NSRC(NSRC), .DATA_W(DW)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_idx(req_idx),
    .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq));

  // fields: req_valid, req_idx, wr_en, addr, wdata, exp_src, exp_int, exp_ofs, exp_irq
  localparam logic [VW-1:0] VEC [NV] = '{
    {1'b1, 5'd5,  1'b0, 2'd0, 32'h0,     20'h00020, 20'h00020, 5'd5,  1'b1},
    {1'b1, 5'd3,  1'b0, 2'd0, 32'h0,     20'h00028, 20'h00028, 5'd3,  1'b1},
    {1'b1, 5'd10, 1'b0, 2'd0, 32'h0,     20'h00428, 20'h00028, 5'd3,  1'b1},
    {1'b0, 5'd0,  1'b1, 2'd0, 32'h8,     20'h00420, 20'h00028, 5'd5,  1'b1},
    {1'b0, 5'd0,  1'b1, 2'd1, 32'h28,    20'h00420, 20'h00000, 5'd5,  1'b1},
    {1'b0, 5'd0,  1'b1, 2'd0, 32'h20,    20'h00400, 20'h00400, 5'd10, 1'b1},
    {1'b1, 5'd10, 1'b1, 2'd0, 32'h400,   20'h00400, 20'h00400, 5'd10, 1'b1},
    {1'b1, 5'd25, 1'b0, 2'd0, 32'h0,     20'h00400, 20'h00400, 5'd10, 1'b1},
    {1'b0, 5'd0,  1'b1, 2'd2, 32'h7,     20'h00400, 20'h00400, 5'd7,  1'b1},
    {1'b0, 5'd0,  1'b1, 2'd0, 32'hFFFFF, 20'h00000, 20'h00400, 5'd7,  1'b0},
    {1'b1, 5'd19, 1'b0, 2'd0, 32'h0,     20'h80000, 20'h80400, 5'd19, 1'b1},
    {1'b1, 5'd0,  1'b1, 2'd1, 32'hFFFFF, 20'h80001, 20'h00001, 5'd0,  1'b1},
    {1'b1, 5'd4,  1'b1, 2'd2, 32'h9,     20'h80011, 20'h00001, 5'd0,  1'b1},
    {1'b0, 5'd0,  1'b1, 2'd3, 32'hFFFF,  20'h80011, 20'h00001, 5'd0,  1'b1}
  };
  string tags [NV] = '{
    "R2 R3 R4 R5", "R3 lowest", "R3 R4 newer higher", "R6 R7 next winner",
    "R9 int clear", "R7 repost", "R8 req beats clear", "R12 out of range",
    "R10 offset load", "R7 R5 empty drop", "R2 top source", "R9 post beats clear",
    "R10 post beats load", "R11 addr3 write"
  };

  task automatic check(input string tag, input string what, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic rd(input logic [1:0] a, output logic [DW-1:0] v);
    addr = a;
    #1;
    v = rdata;
  endtask

  task automatic check_all(input string tag, input logic [19:0] es, input logic [19:0] ei, input logic [4:0] eo, input logic eirq);
    logic [DW-1:0] v;
    rd(2'd0, v); check(tag, "src_pend", v, DW'(es));
    rd(2'd1, v); check(tag, "int_pend", v, DW'(ei));
    rd(2'd2, v); check(tag, "offset", v, DW'(eo));
    check(tag, "irq", DW'(irq), DW'(eirq));
  endtask

  initial begin
    #(200000 * 20);
    fails++;
    $display("FAIL watchdog expired actual running expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [DW-1:0] v;
    repeat (3) @(negedge clk);
    check_all("R1 reset", 20'h0, 20'h0, 5'd0, 1'b0);
    rst_n = 1;
    @(negedge clk);
    check_all("R13 idle", 20'h0, 20'h0, 5'd0, 1'b0);

    for (int k = 0; k < NV; k++) begin
      logic [VW-1:0] e;
      e = VEC[k];
      @(negedge clk);
      req_valid = e[86]; req_idx = e[85:81]; wr_en = e[80];
      addr = e[79:78]; wdata = e[77:46];
      @(negedge clk);
      req_valid = 0; wr_en = 0;
      check_all(tags[k], e[45:26], e[25:6], e[5:1], e[0]);
    end

    rd(2'd3, v); check("R11 addr3 read", "rdata", v, '0);
    @(negedge clk);
    check_all("R13 hold", 20'h80011, 20'h00001, 5'd0, 1'b1);

    rst_n = 0;
    #2;
    check_all("R1 mid reset", 20'h0, 20'h0, 5'd0, 1'b0);
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    req_valid = 1; req_idx = 5'd7;
    @(negedge clk);
    req_valid = 0;
    check_all("R2 after reset", 20'h00080, 20'h00080, 5'd7, 1'b1);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule